// File: doc/BRIEF.md
# Byte-Memory Stack Pointer Engine

This block keeps a 16-bit stack pointer and uses it to run a stack in byte-wide data memory. The stack grows downward. A requester asks for one of four operations: push a byte, pop a byte, push a 16-bit return address, or pop one. The engine drives a single-port byte memory with one access per cycle. It writes back the new pointer and then gives a one-cycle completion pulse. A popped value is returned on a separate output.

The pointer can also be read and written as two bytes through a small register port. The register port decodes an 8-bit register address. A register write that comes in while an operation is running is parked. It is then merged into the pointer in the same edge as that operation's write-back.

Top module: `stack_ptr_engine`

## Requirements
- R1: After reset the pointer is 0x0000, `busy_o` is low and `done_o` is low.
- R2: A byte push (`req_op_i` = 2'b00) writes `req_data_i[7:0]` at address SP in the single access cycle that follows acceptance. The pointer then becomes SP-1.
- R3: A byte pop (`req_op_i` = 2'b01) reads address SP+1 in the single access cycle. The pointer becomes SP+1, and `pop_data_o` becomes {8'h00, byte read}.
- R4: An address push (`req_op_i` = 2'b10) has two access cycles. The first writes `req_data_i[15:8]` at SP. The second writes `req_data_i[7:0]` at SP-1. The pointer then becomes SP-2.
- R5: An address pop (`req_op_i` = 2'b11) has two access cycles. The first reads the low byte at SP+1. The second reads the high byte at SP+2. `pop_data_o` becomes high×256+low and the pointer becomes SP+2.
- R6: All pointer arithmetic and all memory addresses wrap modulo 2^16.
- R7: Register address 0x5D reads and writes the pointer's low byte, and 0x5E reads and writes its high byte. A write to any other register address has no effect, and reading any other address returns 0x00.
- R8: A register write that falls in the acceptance cycle or in any access cycle does not change the pointer until the operation's final edge. At that edge it replaces the matching byte of the computed pointer. Until then the accesses keep using the old pointer.
- R9: A request is accepted only when the engine is idle. `busy_o` is high in every access cycle. The pointer does not change between the accesses of a two-byte operation. `done_o` is a one-cycle pulse in the cycle after the last access, with `busy_o` low. A request that arrives while busy is ignored.
- R10: `mem_we_o` is high only in push access cycles. It is never high in pop access cycles or in idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, taken when idle |
| req_op_i | input | 2 | 00 push byte, 01 pop byte, 10 push address, 11 pop address |
| req_data_i | input | 16 | Push value (byte push uses bits 7:0) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pop_data_o | output | 16 | Result of the last pop |
| mem_addr_o | output | 16 | Memory byte address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_we_o | output | 1 | Memory write enable |
| mem_rdata_i | input | 8 | Memory read data, valid in the same cycle as the address |
| io_addr_i | input | 8 | Register port address |
| io_we_i | input | 1 | Register port write strobe |
| io_wdata_i | input | 8 | Register port write data |
| io_rdata_o | output | 8 | Register port read data |

## Verification
Two functions can fall in the same cycle: a register-port write to a pointer byte and an operation's own pointer write-back. The bench provokes this by writing the high byte in the same cycle that an address push is accepted. It then writes the low byte during the final access cycle. The outcome is judged on three things. The memory addresses must still follow the old pointer. A register read during the operation must still show the old value. After completion the pointer must hold both written bytes and not the computed SP-2.

// File: rtl/sp_engine_pkg.sv
package sp_engine_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned PTR_W  = 2 * BYTE_W;

  typedef enum logic [1:0] {
    OP_PUSH_B = 2'b00,
    OP_POP_B  = 2'b01,
    OP_PUSH_A = 2'b10,
    OP_POP_A  = 2'b11
  } sp_op_e;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_FIRST  = 2'd1,
    S_SECOND = 2'd2
  } seq_state_e;
endpackage

// File: rtl/sp_ptr_reg.sv
module sp_ptr_reg
  import sp_engine_pkg::*;
#(
  parameter int unsigned IO_AW = 8,
  parameter logic [IO_AW-1:0] LO_ADDR = 8'h5D,
  parameter logic [IO_AW-1:0] HI_ADDR = 8'h5E
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IO_AW-1:0]  io_addr_i,
  input  logic              io_we_i,
  input  logic [BYTE_W-1:0] io_wdata_i,
  input  logic              hold_i,
  input  logic              commit_i,
  input  logic [PTR_W-1:0]  next_sp_i,
  output logic [PTR_W-1:0]  sp_o,
  output logic [BYTE_W-1:0] io_rdata_o
);
  logic [PTR_W-1:0]  sp_q;
  logic              pend_lo_v_q, pend_hi_v_q;
  logic [BYTE_W-1:0] pend_lo_q, pend_hi_q;
  logic              hit_lo, hit_hi;
  logic [PTR_W-1:0]  merged_sp;

  assign hit_lo = io_we_i && (io_addr_i == LO_ADDR);
  assign hit_hi = io_we_i && (io_addr_i == HI_ADDR);

  // same-cycle write overrides an older parked byte
  always_comb begin
    merged_sp = next_sp_i;
    if (hit_lo)           merged_sp[BYTE_W-1:0] = io_wdata_i;
    else if (pend_lo_v_q) merged_sp[BYTE_W-1:0] = pend_lo_q;
    if (hit_hi)           merged_sp[PTR_W-1:BYTE_W] = io_wdata_i;
    else if (pend_hi_v_q) merged_sp[PTR_W-1:BYTE_W] = pend_hi_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q        <= '0;
      pend_lo_v_q <= 1'b0;
      pend_hi_v_q <= 1'b0;
      pend_lo_q   <= '0;
      pend_hi_q   <= '0;
    end else if (commit_i) begin
      sp_q        <= merged_sp;
      pend_lo_v_q <= 1'b0;
      pend_hi_v_q <= 1'b0;
    end else if (hold_i) begin
      if (hit_lo) begin
        pend_lo_v_q <= 1'b1;
        pend_lo_q   <= io_wdata_i;
      end
      if (hit_hi) begin
        pend_hi_v_q <= 1'b1;
        pend_hi_q   <= io_wdata_i;
      end
    end else begin
      if (hit_lo) sp_q[BYTE_W-1:0]     <= io_wdata_i;
      if (hit_hi) sp_q[PTR_W-1:BYTE_W] <= io_wdata_i;
    end
  end

  always_comb begin
    if (io_addr_i == LO_ADDR)      io_rdata_o = sp_q[BYTE_W-1:0];
    else if (io_addr_i == HI_ADDR) io_rdata_o = sp_q[PTR_W-1:BYTE_W];
    else                           io_rdata_o = '0;
  end

  assign sp_o = sp_q;

  assert_hold_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !commit_i) |=> $stable(sp_q));
endmodule

// File: rtl/sp_seq.sv
module sp_seq
  import sp_engine_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  sp_op_e            req_op_i,
  input  logic [PTR_W-1:0]  req_data_i,
  input  logic [PTR_W-1:0]  sp_i,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic [PTR_W-1:0]  mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  output logic              accept_o,
  output logic              busy_o,
  output logic              commit_o,
  output logic [PTR_W-1:0]  next_sp_o,
  output logic              done_o,
  output logic [PTR_W-1:0]  pop_data_o
);
  seq_state_e        state_q, state_d;
  sp_op_e            op_q;
  logic [PTR_W-1:0]  data_q;
  logic [BYTE_W-1:0] lo_q;
  logic              done_q;
  logic [PTR_W-1:0]  pop_q;

  assign accept_o = (state_q == S_IDLE) && req_valid_i;
  assign busy_o   = (state_q != S_IDLE);

  always_comb begin
    state_d     = state_q;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    mem_we_o    = 1'b0;
    commit_o    = 1'b0;
    next_sp_o   = sp_i;
    unique case (state_q)
      S_IDLE: if (accept_o) state_d = S_FIRST;
      S_FIRST: begin
        unique case (op_q)
          OP_PUSH_B: begin
            mem_addr_o  = sp_i;
            mem_wdata_o = data_q[BYTE_W-1:0];
            mem_we_o    = 1'b1;
            commit_o    = 1'b1;
            next_sp_o   = sp_i - PTR_W'(1);
            state_d     = S_IDLE;
          end
          OP_POP_B: begin
            mem_addr_o = sp_i + PTR_W'(1);
            commit_o   = 1'b1;
            next_sp_o  = sp_i + PTR_W'(1);
            state_d    = S_IDLE;
          end
          OP_PUSH_A: begin
            mem_addr_o  = sp_i;
            mem_wdata_o = data_q[PTR_W-1:BYTE_W];
            mem_we_o    = 1'b1;
            state_d     = S_SECOND;
          end
          OP_POP_A: begin
            mem_addr_o = sp_i + PTR_W'(1);
            state_d    = S_SECOND;
          end
          default: state_d = S_IDLE;
        endcase
      end
      S_SECOND: begin
        commit_o = 1'b1;
        state_d  = S_IDLE;
        if (op_q == OP_PUSH_A) begin
          mem_addr_o  = sp_i - PTR_W'(1);
          mem_wdata_o = data_q[BYTE_W-1:0];
          mem_we_o    = 1'b1;
          next_sp_o   = sp_i - PTR_W'(2);
        end else begin
          mem_addr_o = sp_i + PTR_W'(2);
          next_sp_o  = sp_i + PTR_W'(2);
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      op_q    <= OP_PUSH_B;
      data_q  <= '0;
      lo_q    <= '0;
      done_q  <= 1'b0;
      pop_q   <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= commit_o;
      if (accept_o) begin
        op_q   <= req_op_i;
        data_q <= req_data_i;
      end
      if (state_q == S_FIRST && op_q == OP_POP_A) lo_q <= mem_rdata_i;
      if (commit_o && op_q == OP_POP_B) pop_q <= {{BYTE_W{1'b0}}, mem_rdata_i};
      if (commit_o && op_q == OP_POP_A) pop_q <= {mem_rdata_i, lo_q};
    end
  end

  assign done_o     = done_q;
  assign pop_data_o = pop_q;

  assert_we_in_push_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (busy_o && (op_q == OP_PUSH_B || op_q == OP_PUSH_A)));
  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_push_addr_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_SECOND && op_q == OP_PUSH_A) |-> (mem_addr_o == $past(mem_addr_o) - PTR_W'(1)));
  assert_pop_addr_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_SECOND && op_q == OP_POP_A) |-> (mem_addr_o == $past(mem_addr_o) + PTR_W'(1)));
endmodule

// File: rtl/stack_ptr_engine.sv
module stack_ptr_engine
  import sp_engine_pkg::*;
#(
  parameter int unsigned IO_AW = 8,
  parameter logic [IO_AW-1:0] SP_LO_ADDR = 8'h5D,
  parameter logic [IO_AW-1:0] SP_HI_ADDR = 8'h5E
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic [PTR_W-1:0]  req_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [PTR_W-1:0]  pop_data_o,
  output logic [PTR_W-1:0]  mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  input  logic [IO_AW-1:0]  io_addr_i,
  input  logic              io_we_i,
  input  logic [BYTE_W-1:0] io_wdata_i,
  output logic [BYTE_W-1:0] io_rdata_o
);
  logic [PTR_W-1:0] sp, next_sp;
  logic             accept, commit, busy;

  sp_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_op_i    (sp_op_e'(req_op_i)),
    .req_data_i  (req_data_i),
    .sp_i        (sp),
    .mem_rdata_i (mem_rdata_i),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_we_o    (mem_we_o),
    .accept_o    (accept),
    .busy_o      (busy),
    .commit_o    (commit),
    .next_sp_o   (next_sp),
    .done_o      (done_o),
    .pop_data_o  (pop_data_o)
  );

  sp_ptr_reg #(
    .IO_AW   (IO_AW),
    .LO_ADDR (SP_LO_ADDR),
    .HI_ADDR (SP_HI_ADDR)
  ) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .io_addr_i  (io_addr_i),
    .io_we_i    (io_we_i),
    .io_wdata_i (io_wdata_i),
    .hold_i     (busy | accept),
    .commit_i   (commit),
    .next_sp_i  (next_sp),
    .sp_o       (sp),
    .io_rdata_o (io_rdata_o)
  );

  assign busy_o = busy;

  assert_sp_fixed_in_op_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !commit) |=> $stable(sp));
endmodule

// File: tb/stack_ptr_engine_bench.sv
module stack_ptr_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'b00;
  logic [15:0] req_data = '0;
  logic        busy, done, mem_we, io_we = 1'b0;
  logic [15:0] pop_data, mem_addr;
  logic [7:0]  mem_wdata, mem_rdata, io_addr = 8'h00, io_wdata = 8'h00, io_rdata;
  logic [7:0]  mem [256];
  int checks = 0, errors = 0, cycles = 0;
  bit  finished = 1'b0;

  always #4 clk = ~clk;

  stack_ptr_engine u_stack_ptr_engine (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_data_i(req_data), .busy_o(busy), .done_o(done), .pop_data_o(pop_data),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_we_o(mem_we),
    .mem_rdata_i(mem_rdata), .io_addr_i(io_addr), .io_we_i(io_we),
    .io_wdata_i(io_wdata), .io_rdata_o(io_rdata)
  );

  always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
  assign mem_rdata = mem[mem_addr[7:0]];

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic read_sp(output logic [15:0] v);
    io_we = 1'b0;
    io_addr = 8'h5D; #1 v[7:0] = io_rdata;
    io_addr = 8'h5E; #1 v[15:8] = io_rdata;
  endtask

  task automatic set_sp(input logic [15:0] v);
    @(negedge clk); io_we = 1'b1; io_addr = 8'h5D; io_wdata = v[7:0];
    @(negedge clk); io_addr = 8'h5E; io_wdata = v[15:8];
    @(negedge clk); io_we = 1'b0;
  endtask

  // leaves the bench in the first access cycle
  task automatic start(input logic [1:0] op, input logic [15:0] d);
    @(negedge clk); req_valid = 1'b1; req_op = op; req_data = d;
    @(negedge clk); req_valid = 1'b0; #1;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    read_sp(v);
    chk("R1 sp", v, 16'h0000);
    chk("R1 busy", 16'(busy), 16'h0);
    chk("R1 done", 16'(done), 16'h0);
  endtask

  task automatic t_push_byte;
    logic [15:0] v;
    set_sp(16'h0180);
    start(2'b00, 16'h00A5);
    chk("R2 addr", mem_addr, 16'h0180);
    chk("R2 wdata", 16'(mem_wdata), 16'h00A5);
    chk("R10 we push", 16'(mem_we), 16'h1);
    chk("R9 busy", 16'(busy), 16'h1);
    @(negedge clk); #1;
    chk("R9 done", 16'(done), 16'h1);
    chk("R9 idle at done", 16'(busy), 16'h0);
    read_sp(v);
    chk("R2 sp", v, 16'h017F);
    chk("R2 mem", 16'(mem[8'h80]), 16'h00A5);
    @(negedge clk); #1;
    chk("R9 pulse", 16'(done), 16'h0);
  endtask

  task automatic t_pop_byte;
    logic [15:0] v;
    start(2'b01, 16'h0000);
    chk("R3 addr", mem_addr, 16'h0180);
    chk("R10 no we pop", 16'(mem_we), 16'h0);
    @(negedge clk); #1;
    chk("R3 done", 16'(done), 16'h1);
    chk("R3 data", pop_data, 16'h00A5);
    read_sp(v);
    chk("R3 sp", v, 16'h0180);
  endtask

  task automatic t_push_addr;
    logic [15:0] v;
    set_sp(16'h0140);
    start(2'b10, 16'h1234);
    chk("R4 addr1", mem_addr, 16'h0140);
    chk("R4 data1", 16'(mem_wdata), 16'h0012);
    @(negedge clk); #1;
    chk("R4 addr2", mem_addr, 16'h013F);
    chk("R4 data2", 16'(mem_wdata), 16'h0034);
    chk("R9 busy2", 16'(busy), 16'h1);
    read_sp(v);
    chk("R9 sp held", v, 16'h0140);
    @(negedge clk); #1;
    chk("R4 done", 16'(done), 16'h1);
    read_sp(v);
    chk("R4 sp", v, 16'h013E);
  endtask

  task automatic t_pop_addr;
    logic [15:0] v;
    start(2'b11, 16'h0000);
    chk("R5 addr1", mem_addr, 16'h013F);
    chk("R10 no we pop addr", 16'(mem_we), 16'h0);
    @(negedge clk); #1;
    chk("R5 addr2", mem_addr, 16'h0140);
    @(negedge clk); #1;
    chk("R5 done", 16'(done), 16'h1);
    chk("R5 data", pop_data, 16'h1234);
    read_sp(v);
    chk("R5 sp", v, 16'h0140);
  endtask

  task automatic t_wrap;
    logic [15:0] v;
    set_sp(16'h0000);
    start(2'b00, 16'h005A);
    chk("R6 push addr", mem_addr, 16'h0000);
    @(negedge clk); #1;
    read_sp(v);
    chk("R6 sp under", v, 16'hFFFF);
    start(2'b01, 16'h0000);
    chk("R6 pop addr", mem_addr, 16'h0000);
    @(negedge clk); #1;
    chk("R6 pop data", pop_data, 16'h005A);
    start(2'b10, 16'hBEEF);
    @(negedge clk); #1;
    chk("R6 addr2 wrap", mem_addr, 16'hFFFF);
    @(negedge clk); #1;
    read_sp(v);
    chk("R6 sp", v, 16'hFFFE);
    start(2'b11, 16'h0000);
    chk("R6 pop lo", mem_addr, 16'hFFFF);
    @(negedge clk); #1;
    chk("R6 pop hi", mem_addr, 16'h0000);
    @(negedge clk); #1;
    chk("R6 pop word", pop_data, 16'hBEEF);
    read_sp(v);
    chk("R6 sp back", v, 16'h0000);
  endtask

  task automatic t_io;
    logic [15:0] v;
    set_sp(16'h2468);
    @(negedge clk); io_we = 1'b1; io_addr = 8'h5C; io_wdata = 8'h77;
    @(negedge clk); io_we = 1'b0; #1;
    chk("R7 other read", 16'(io_rdata), 16'h0000);
    read_sp(v);
    chk("R7 sp kept", v, 16'h2468);
  endtask

  task automatic t_collide;
    logic [15:0] v;
    set_sp(16'h0200);
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'b10; req_data = 16'hCAFE;
    io_we = 1'b1; io_addr = 8'h5E; io_wdata = 8'h03;
    @(negedge clk); req_valid = 1'b0; io_we = 1'b0; #1;
    chk("R8 addr1 old sp", mem_addr, 16'h0200);
    read_sp(v);
    chk("R8 sp deferred", v, 16'h0200);
    @(negedge clk);
    io_we = 1'b1; io_addr = 8'h5D; io_wdata = 8'h10; #1;
    chk("R8 addr2 old sp", mem_addr, 16'h01FF);
    @(negedge clk); io_we = 1'b0; #1;
    chk("R8 done", 16'(done), 16'h1);
    read_sp(v);
    chk("R8 merged sp", v, 16'h0310);
  endtask

  task automatic t_busy_ignore;
    logic [15:0] v;
    set_sp(16'h0050);
    start(2'b00, 16'h0011);
    req_valid = 1'b1; req_op = 2'b01;
    @(negedge clk); req_valid = 1'b0; #1;
    chk("R9 done ign", 16'(done), 16'h1);
    @(negedge clk); #1;
    chk("R9 ignored req", 16'(busy), 16'h0);
    read_sp(v);
    chk("R9 sp ign", v, 16'h004F);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog got %0d expected below 100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_push_byte();
    t_pop_byte();
    t_push_addr();
    t_pop_addr();
    t_wrap();
    t_io();
    t_collide();
    t_busy_ignore();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule